// File: doc/BRIEF.md
# Coherence Directory Home Controller

This block is the home-node side of a directory coherence scheme for a fixed group of caching sites. For each memory block in a small direct-indexed table it keeps a directory entry. The entry holds a sharer mask with one presence bit per site, a dirty flag, an owner identifier and a state. The state is one of shared-stable, modified-stable, invalidation-pending or recall-pending. Sites send shared-read and exclusive-read requests. The home answers with data replies, probes other sites with invalidate, writeback or flush requests, and absorbs their responses. A small backing memory holds the block data and is refreshed whenever an owner returns modified data.

The home handles one transaction at a time. While a block sits in a pending state, `req_ready` is low and any new request stays held at the input until the block settles again. During an invalidation round, a counter loaded with the number of invalidated sharers counts the acknowledgements down. The exclusive reply leaves only when that count runs out. Replies and probes are registered, single-cycle pulses. The network is assumed reliable and in order per source and destination pair.

Top module: `coh_home_ctrl`

## Requirements
- R1: After reset every block is shared-stable with an empty sharer set, block b holds data 16'hA000 + b, `req_ready` is 1, and `rep_valid` and `prb_valid` are 0.
- R2: A shared read (`req_excl`=0) to a block with no owner gives a shared reply (`rep_excl`=0) to the requester, carrying the memory data, in the cycle after acceptance. It adds the requester to the sharers.
- R3: An exclusive read (`req_excl`=1) to an ownerless block whose only possible sharer is the requester gives an exclusive reply (`rep_excl`=1) in the cycle after acceptance. The requester becomes the sole owner.
- R4: An exclusive read to a block with other sharers sends one invalidate probe (`prb_kind`=0) to each sharer other than the requester. The probes go one per cycle in ascending site order, the first two cycles after acceptance.
- R5: The exclusive reply after an invalidation round is sent only once an invalidate acknowledgement (`rsp_kind`=0) has arrived from every probed sharer. It appears in the cycle after the last acknowledgement, carrying the memory data.
- R6: A shared read to an owned block sends a writeback probe (`prb_kind`=1) to the owner in the cycle after acceptance. On the owner's writeback response (`rsp_kind`=1) carrying value v, memory takes v and a shared reply with v follows one cycle later. Owner and requester both become sharers.
- R7: An exclusive read to a block owned by another site sends a flush probe (`prb_kind`=2) to the owner in the cycle after acceptance. On the flush response (`rsp_kind`=2) with value v, memory takes v and an exclusive reply with v follows one cycle later. The requester becomes sole owner and the old owner holds no copy.
- R8: While an invalidation round or recall is pending, `req_ready` is 0 and requests are held. A held request is accepted in the first cycle the home is idle again.
- R9: A probe response whose kind, site or block does not match an outstanding probe, or that repeats an acknowledgement already counted, has no effect.
- R10: At most one site is ever recorded as owner. A recall always targets only the latest owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Home idle; request accepted on this edge |
| req_excl | input | 1 | 1 exclusive read, 0 shared read |
| req_site | input | SITE_W | Requesting site |
| req_blk | input | BLK_W | Requested block |
| rep_valid | output | 1 | Data reply pulse |
| rep_excl | output | 1 | 1 exclusive reply, 0 shared reply |
| rep_site | output | SITE_W | Destination site of reply |
| rep_blk | output | BLK_W | Block of reply |
| rep_data | output | DATA_W | Block data |
| prb_valid | output | 1 | Probe pulse |
| prb_kind | output | 2 | 0 invalidate, 1 writeback, 2 flush |
| prb_site | output | SITE_W | Probed site |
| prb_blk | output | BLK_W | Probed block |
| rsp_valid | input | 1 | Probe response present |
| rsp_kind | input | 2 | 0 invalidate ack, 1 writeback data, 2 flush data |
| rsp_site | input | SITE_W | Responding site |
| rsp_blk | input | BLK_W | Block of response |
| rsp_data | input | DATA_W | Returned data for writeback/flush |

## Verification
Replies to requests served directly from memory are due in the cycle right after the accepting edge. A recall probe is also due one cycle after acceptance, while the first invalidate probe is due two cycles after, with one more per cycle. A reply that follows a probe response is due in the cycle after the edge that took the response. Every request and response is driven just after a falling edge and removed at the next falling edge, so each result is sampled at exactly the falling edge where it is due. The quiet cycles, where neither a probe nor a reply may appear, are sampled the same way.

// File: rtl/coh_pkg.sv
package coh_pkg;
    parameter int SITES    = 4;
    parameter int BLOCKS   = 8;
    parameter int DATA_W   = 16;
    parameter int MEM_BASE = 'hA000;

    localparam int SITE_W = $clog2(SITES);
    localparam int BLK_W  = $clog2(BLOCKS);
    localparam int CNT_W  = $clog2(SITES + 1);

    typedef logic [SITE_W-1:0] site_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SITES-1:0]  site_mask_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {DIR_R, DIR_W, DIR_TR, DIR_TW} dir_state_e;
    typedef enum logic [1:0] {PRB_INV = 2'd0, PRB_WB = 2'd1, PRB_FLUSH = 2'd2} prb_kind_e;
    typedef enum logic [1:0] {RSP_INV = 2'd0, RSP_WB = 2'd1, RSP_FLUSH = 2'd2} rsp_kind_e;
    typedef enum logic [1:0] {H_IDLE, H_INV, H_RECALL} home_state_e;

    typedef struct packed {
        dir_state_e st;
        logic       dirty;
        site_t      owner;
        site_mask_t sharers;
    } dir_entry_t;

    function automatic word_t mem_init(blk_t b);
        return word_t'(MEM_BASE) + word_t'(b);
    endfunction

    function automatic site_mask_t site_bit(site_t s);
        return site_mask_t'(1) << s;
    endfunction
endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table import coh_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  blk_t       rd_blk,
    output dir_entry_t rd_entry,
    input  logic       wr_en,
    input  blk_t       wr_blk,
    input  dir_entry_t wr_entry
);
    dir_entry_t tbl_q [BLOCKS];

    assign rd_entry = tbl_q[rd_blk];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLOCKS; i++)
                tbl_q[i] <= '{st: DIR_R, dirty: 1'b0, owner: '0, sharers: '0};
        end else if (wr_en) begin
            tbl_q[wr_blk] <= wr_entry;
        end
    end
endmodule

// File: rtl/coh_backing_mem.sv
module coh_backing_mem import coh_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  blk_t  rd_blk,
    output word_t rd_data,
    input  logic  wr_en,
    input  blk_t  wr_blk,
    input  word_t wr_data
);
    word_t mem_q [BLOCKS];

    assign rd_data = mem_q[rd_blk];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLOCKS; i++)
                mem_q[i] <= mem_init(blk_t'(i));
        end else if (wr_en) begin
            mem_q[wr_blk] <= wr_data;
        end
    end
endmodule

// File: rtl/coh_sharer_pick.sv
module coh_sharer_pick import coh_pkg::*; (
    input  site_mask_t mask,
    output logic       any,
    output site_t      first,
    output cnt_t       count
);
    always_comb begin
        first = '0;
        for (int i = SITES - 1; i >= 0; i--)
            if (mask[i]) first = site_t'(i);
        count = cnt_t'($countones(mask));
        any   = |mask;
    end
endmodule

// File: rtl/coh_ack_ctr.sv
module coh_ack_ctr import coh_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t load_val,
    input  logic dec,
    output cnt_t count
);
    always_ff @(posedge clk) begin
        if (rst)                   count <= '0;
        else if (load)             count <= load_val;
        else if (dec && count != 0) count <= count - cnt_t'(1);
    end
endmodule

// File: rtl/coh_home_ctrl.sv
module coh_home_ctrl import coh_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_excl,
    input  logic [SITE_W-1:0] req_site,
    input  logic [BLK_W-1:0]  req_blk,
    output logic              rep_valid,
    output logic              rep_excl,
    output logic [SITE_W-1:0] rep_site,
    output logic [BLK_W-1:0]  rep_blk,
    output logic [DATA_W-1:0] rep_data,
    output logic              prb_valid,
    output logic [1:0]        prb_kind,
    output logic [SITE_W-1:0] prb_site,
    output logic [BLK_W-1:0]  prb_blk,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_kind,
    input  logic [SITE_W-1:0] rsp_site,
    input  logic [BLK_W-1:0]  rsp_blk,
    input  logic [DATA_W-1:0] rsp_data
);
    home_state_e st_q, st_d;
    blk_t        cur_blk_q;
    site_t       cur_site_q, owner_q;
    logic        cur_excl_q;
    site_mask_t  pend_q, pend_d, wait_q, wait_d;

    blk_t        lk_blk;
    dir_entry_t  rd_entry, wr_entry;
    logic        dir_we;
    word_t       mem_rd, mem_wd;
    logic        mem_we;

    site_mask_t  me_req, others;
    logic        oth_any, iss_any;
    site_t       oth_first, iss_first;
    cnt_t        oth_cnt, iss_cnt, ack_cnt;
    logic        ctr_load, ctr_dec;

    logic        acc, ack_ok, recall_ok;
    logic        rep_set, rep_excl_d, prb_set;
    site_t       rep_site_d, prb_site_d;
    word_t       rep_data_d;
    prb_kind_e   prb_kind_d;

    assign req_ready = (st_q == H_IDLE);
    assign lk_blk    = (st_q == H_IDLE) ? req_blk : cur_blk_q;
    assign me_req    = site_bit(req_site);
    assign others    = rd_entry.sharers & ~me_req;

    coh_dir_table u_dir (
        .clk(clk), .rst(rst), .rd_blk(lk_blk), .rd_entry(rd_entry),
        .wr_en(dir_we), .wr_blk(lk_blk), .wr_entry(wr_entry)
    );

    coh_backing_mem u_mem (
        .clk(clk), .rst(rst), .rd_blk(lk_blk), .rd_data(mem_rd),
        .wr_en(mem_we), .wr_blk(cur_blk_q), .wr_data(mem_wd)
    );

    coh_sharer_pick u_oth_pick (
        .mask(others), .any(oth_any), .first(oth_first), .count(oth_cnt)
    );

    coh_sharer_pick u_iss_pick (
        .mask(pend_q), .any(iss_any), .first(iss_first), .count(iss_cnt)
    );

    coh_ack_ctr u_ack (
        .clk(clk), .rst(rst), .load(ctr_load), .load_val(oth_cnt),
        .dec(ctr_dec), .count(ack_cnt)
    );

    always_comb begin
        st_d       = st_q;
        pend_d     = pend_q;
        wait_d     = wait_q;
        dir_we     = 1'b0;
        wr_entry   = rd_entry;
        mem_we     = 1'b0;
        mem_wd     = rsp_data;
        acc        = 1'b0;
        ack_ok     = 1'b0;
        recall_ok  = 1'b0;
        rep_set    = 1'b0;
        rep_excl_d = cur_excl_q;
        rep_site_d = cur_site_q;
        rep_data_d = mem_rd;
        prb_set    = 1'b0;
        prb_kind_d = PRB_INV;
        prb_site_d = iss_first;
        ctr_load   = 1'b0;
        ctr_dec    = 1'b0;

        unique case (st_q)
            H_IDLE: begin
                if (req_valid) begin
                    acc        = 1'b1;
                    rep_site_d = req_site;
                    rep_excl_d = req_excl;
                    unique case (rd_entry.st)
                        DIR_R: begin
                            dir_we = 1'b1;
                            if (!req_excl) begin
                                wr_entry.sharers = rd_entry.sharers | me_req;
                                rep_set = 1'b1;
                            end else if (!oth_any) begin
                                wr_entry = '{st: DIR_W, dirty: 1'b1, owner: req_site, sharers: me_req};
                                rep_set  = 1'b1;
                            end else begin
                                wr_entry.st = DIR_TR;
                                pend_d      = others;
                                wait_d      = others;
                                ctr_load    = 1'b1;
                                st_d        = H_INV;
                            end
                        end
                        DIR_W: begin
                            if (rd_entry.owner == req_site || !rd_entry.dirty) begin
                                rep_set = 1'b1;
                            end else begin
                                dir_we      = 1'b1;
                                wr_entry.st = DIR_TW;
                                prb_set     = 1'b1;
                                prb_kind_d  = req_excl ? PRB_FLUSH : PRB_WB;
                                prb_site_d  = rd_entry.owner;
                                st_d        = H_RECALL;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            H_INV: begin
                if (iss_any) begin
                    prb_set = 1'b1;
                    pend_d  = pend_q & ~site_bit(iss_first);
                end
                ack_ok = rsp_valid && (rsp_kind == RSP_INV) && (rsp_blk == cur_blk_q)
                         && wait_q[rsp_site] && !pend_q[rsp_site];
                if (ack_ok) begin
                    ctr_dec = 1'b1;
                    wait_d  = wait_q & ~site_bit(rsp_site);
                    if (ack_cnt == cnt_t'(1)) begin
                        dir_we     = 1'b1;
                        wr_entry   = '{st: DIR_W, dirty: 1'b1, owner: cur_site_q,
                                       sharers: site_bit(cur_site_q)};
                        rep_set    = 1'b1;
                        rep_excl_d = 1'b1;
                        st_d       = H_IDLE;
                    end
                end
            end
            H_RECALL: begin
                recall_ok = rsp_valid && (rsp_site == owner_q) && (rsp_blk == cur_blk_q)
                            && (rsp_kind == (cur_excl_q ? RSP_FLUSH : RSP_WB));
                if (recall_ok) begin
                    mem_we     = 1'b1;
                    dir_we     = 1'b1;
                    rep_set    = 1'b1;
                    rep_data_d = rsp_data;
                    if (cur_excl_q)
                        wr_entry = '{st: DIR_W, dirty: 1'b1, owner: cur_site_q,
                                     sharers: site_bit(cur_site_q)};
                    else
                        wr_entry = '{st: DIR_R, dirty: 1'b0, owner: '0,
                                     sharers: site_bit(owner_q) | site_bit(cur_site_q)};
                    st_d = H_IDLE;
                end
            end
            default: st_d = H_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= H_IDLE;
            pend_q     <= '0;
            wait_q     <= '0;
            cur_blk_q  <= '0;
            cur_site_q <= '0;
            cur_excl_q <= 1'b0;
            owner_q    <= '0;
            rep_valid  <= 1'b0;
            rep_excl   <= 1'b0;
            rep_site   <= '0;
            rep_blk    <= '0;
            rep_data   <= '0;
            prb_valid  <= 1'b0;
            prb_kind   <= '0;
            prb_site   <= '0;
            prb_blk    <= '0;
        end else begin
            st_q      <= st_d;
            pend_q    <= pend_d;
            wait_q    <= wait_d;
            rep_valid <= rep_set;
            prb_valid <= prb_set;
            if (acc) begin
                cur_blk_q  <= req_blk;
                cur_site_q <= req_site;
                cur_excl_q <= req_excl;
                owner_q    <= rd_entry.owner;
            end
            if (rep_set) begin
                rep_excl <= rep_excl_d;
                rep_site <= rep_site_d;
                rep_blk  <= lk_blk;
                rep_data <= rep_data_d;
            end
            if (prb_set) begin
                prb_kind <= prb_kind_d;
                prb_site <= prb_site_d;
                prb_blk  <= lk_blk;
            end
        end
    end
endmodule

// File: rtl/coh_home_chk.sv
module coh_home_chk import coh_pkg::*; (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rep_valid,
    input logic       prb_valid,
    input logic       rsp_valid,
    input logic       dir_we,
    input dir_entry_t wr_entry
);
    // R8
    busy_probe_chk: assert property (@(posedge clk) disable iff (rst)
        prb_valid |-> !req_ready);

    // R2
    accept_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rep_valid || !req_ready));

    // R5
    reply_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rep_valid |-> ($past(req_valid && req_ready) || $past(rsp_valid)));

    // R4
    reply_probe_apart_chk: assert property (@(posedge clk) disable iff (rst)
        rep_valid |-> !prb_valid);

    // R10
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_we && wr_entry.st == DIR_W) |-> ($countones(wr_entry.sharers) == 1));

    // R6
    shared_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (dir_we && wr_entry.st == DIR_R) |-> !wr_entry.dirty);
endmodule

bind coh_home_ctrl coh_home_chk i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rep_valid(rep_valid), .prb_valid(prb_valid), .rsp_valid(rsp_valid),
    .dir_we(dir_we), .wr_entry(wr_entry)
);

// File: tb/test_coh_home_ctrl.sv
module test_coh_home_ctrl;
    import coh_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_excl = 1'b0;
    site_t req_site = '0;
    blk_t  req_blk = '0;
    logic req_ready, rep_valid, rep_excl, prb_valid;
    site_t rep_site, prb_site;
    blk_t  rep_blk, prb_blk;
    word_t rep_data;
    logic [1:0] prb_kind;
    logic rsp_valid = 1'b0;
    logic [1:0] rsp_kind = '0;
    site_t rsp_site = '0;
    blk_t  rsp_blk = '0;
    word_t rsp_data = '0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    coh_home_ctrl i_coh_home_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_excl(req_excl),
        .req_site(req_site), .req_blk(req_blk),
        .rep_valid(rep_valid), .rep_excl(rep_excl), .rep_site(rep_site),
        .rep_blk(rep_blk), .rep_data(rep_data),
        .prb_valid(prb_valid), .prb_kind(prb_kind), .prb_site(prb_site), .prb_blk(prb_blk),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_site(rsp_site),
        .rsp_blk(rsp_blk), .rsp_data(rsp_data)
    );

    task automatic check(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic send_req(input logic ex, input int s, input int b);
        @(negedge clk);
        req_valid = 1'b1; req_excl = ex; req_site = site_t'(s); req_blk = blk_t'(b);
        check("R8", "ready when idle", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_rsp(input rsp_kind_e k, input int s, input int b, input word_t d);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_kind = k; rsp_site = site_t'(s); rsp_blk = blk_t'(b); rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic expect_rep(input string r, input logic ex, input int s, input int b, input word_t d);
        check(r, "rep_valid", 32'(rep_valid), 1);
        check(r, "rep_excl", 32'(rep_excl), 32'(ex));
        check(r, "rep_site", 32'(rep_site), 32'(s));
        check(r, "rep_blk", 32'(rep_blk), 32'(b));
        check(r, "rep_data", 32'(rep_data), 32'(d));
    endtask

    task automatic expect_prb(input string r, input prb_kind_e k, input int s, input int b);
        check(r, "prb_valid", 32'(prb_valid), 1);
        check(r, "prb_kind", 32'(prb_kind), 32'(k));
        check(r, "prb_site", 32'(prb_site), 32'(s));
        check(r, "prb_blk", 32'(prb_blk), 32'(b));
    endtask

    task automatic t_reset;
        check("R1", "ready after reset", 32'(req_ready), 1);
        check("R1", "no reply after reset", 32'(rep_valid), 0);
        check("R1", "no probe after reset", 32'(prb_valid), 0);
        send_req(1'b0, 1, 7);
        expect_rep("R1", 1'b0, 1, 7, 16'hA007);
    endtask

    task automatic t_invalidate_round;
        send_req(1'b0, 0, 3);
        expect_rep("R2", 1'b0, 0, 3, 16'hA003);
        send_req(1'b0, 1, 3);
        expect_rep("R2", 1'b0, 1, 3, 16'hA003);
        check("R2", "no probe on clean read", 32'(prb_valid), 0);
        send_req(1'b1, 2, 3);
        check("R4", "no reply at acceptance", 32'(rep_valid), 0);
        check("R4", "no probe yet", 32'(prb_valid), 0);
        check("R8", "busy in round", 32'(req_ready), 0);
        @(negedge clk); expect_prb("R4", PRB_INV, 0, 3);
        @(negedge clk); expect_prb("R4", PRB_INV, 1, 3);
        @(negedge clk); check("R4", "probes end", 32'(prb_valid), 0);
        req_valid = 1'b1; req_excl = 1'b0; req_site = site_t'(3); req_blk = blk_t'(3);
        check("R8", "held while pending", 32'(req_ready), 0);
        send_rsp(RSP_INV, 0, 4, '0);
        check("R9", "wrong block ack ignored", 32'(rep_valid), 0);
        send_rsp(RSP_INV, 0, 3, '0);
        check("R5", "one ack outstanding", 32'(rep_valid), 0);
        send_rsp(RSP_INV, 0, 3, '0);
        check("R9", "duplicate ack ignored", 32'(rep_valid), 0);
        send_rsp(RSP_INV, 1, 3, '0);
        expect_rep("R5", 1'b1, 2, 3, 16'hA003);
        check("R8", "idle after grant", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_prb("R6", PRB_WB, 2, 3);
        check("R8", "held request taken", 32'(rep_valid), 0);
        send_rsp(RSP_WB, 2, 3, 16'h1234);
        expect_rep("R6", 1'b0, 3, 3, 16'h1234);
        send_req(1'b0, 0, 3);
        expect_rep("R6", 1'b0, 0, 3, 16'h1234);
        send_req(1'b1, 1, 3);
        @(negedge clk); expect_prb("R6", PRB_INV, 0, 3);
        @(negedge clk); expect_prb("R6", PRB_INV, 2, 3);
        @(negedge clk); expect_prb("R6", PRB_INV, 3, 3);
        send_rsp(RSP_INV, 3, 3, '0);
        send_rsp(RSP_INV, 0, 3, '0);
        check("R5", "two of three acks", 32'(rep_valid), 0);
        send_rsp(RSP_INV, 2, 3, '0);
        expect_rep("R5", 1'b1, 1, 3, 16'h1234);
    endtask

    task automatic t_excl_clean;
        send_req(1'b1, 3, 5);
        expect_rep("R3", 1'b1, 3, 5, 16'hA005);
        check("R3", "stays ready", 32'(req_ready), 1);
        send_req(1'b0, 0, 6);
        expect_rep("R2", 1'b0, 0, 6, 16'hA006);
        send_req(1'b1, 0, 6);
        expect_rep("R3", 1'b1, 0, 6, 16'hA006);
        check("R3", "upgrade without probe", 32'(prb_valid), 0);
    endtask

    task automatic t_flush;
        send_req(1'b1, 1, 5);
        expect_prb("R7", PRB_FLUSH, 3, 5);
        check("R7", "no reply before flush", 32'(rep_valid), 0);
        send_rsp(RSP_WB, 3, 5, 16'h1111);
        check("R9", "wrong kind ignored", 32'(rep_valid), 0);
        send_rsp(RSP_FLUSH, 2, 5, 16'h2222);
        check("R9", "wrong site ignored", 32'(rep_valid), 0);
        send_rsp(RSP_FLUSH, 3, 5, 16'hBEEF);
        expect_rep("R7", 1'b1, 1, 5, 16'hBEEF);
    endtask

    task automatic t_single_owner;
        send_req(1'b1, 0, 5);
        expect_prb("R10", PRB_FLUSH, 1, 5);
        @(negedge clk); check("R10", "one recall only", 32'(prb_valid), 0);
        send_rsp(RSP_FLUSH, 1, 5, 16'hCAFE);
        expect_rep("R10", 1'b1, 0, 5, 16'hCAFE);
        send_req(1'b0, 2, 5);
        expect_prb("R10", PRB_WB, 0, 5);
        send_rsp(RSP_WB, 0, 5, 16'hD00D);
        expect_rep("R6", 1'b0, 2, 5, 16'hD00D);
        send_req(1'b1, 3, 5);
        @(negedge clk); expect_prb("R7", PRB_INV, 0, 5);
        @(negedge clk); expect_prb("R7", PRB_INV, 2, 5);
        @(negedge clk); check("R7", "old owner not probed", 32'(prb_valid), 0);
        send_rsp(RSP_INV, 2, 5, '0);
        send_rsp(RSP_INV, 0, 5, '0);
        expect_rep("R7", 1'b1, 3, 5, 16'hD00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_invalidate_round();
        t_excl_clean();
        t_flush();
        t_single_owner();
        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule